// File: doc/BRIEF.md
# Port pin interrupt detector

This block watches the 32 inputs of a general-purpose port and records per-pin trigger events. Each pin carries a 4-bit trigger mode that selects one of several conditions: an edge that should start a DMA transfer, an edge that only records a status flag, an edge that raises the interrupt, or a level that raises the interrupt. When the chosen condition occurs, the pin's status flag sets. The flags of pins in interrupt modes are ORed onto a combined interrupt line, and the flags of pins in DMA modes are ORed onto a DMA request line. Both lines are registered.

Software reads the status word and clears flags by writing ones to them. A level trigger whose level is still present sets its flag again straight after the clear. A DMA-complete pulse clears every flag whose pin is in a DMA mode. Trigger modes can be written one pin at a time. They can also be written in bulk through two group registers, each of which covers 16 pins and carries a pin mask in its upper half.

Top module: `pin_irq_detect`

## Requirements
- R1: After a synchronous reset every status flag, every trigger mode, `irq_req` and `dma_req` read as zero.
- R2: Register map. Addresses 0 to 31 hold the trigger mode of pin n in data bits [3:0]. Address 32 is the status word. A read returns on `reg_rdata` one clock after the address is presented.
- R3: Modes 0, 4, 13, 14 and 15 never set a flag, and the pin drives neither output.
- R4: Modes 1, 2 and 3 set the flag on a rising edge, a falling edge and either edge respectively, and assert `dma_req`. An input change driven before clock edge k sets the flag at edge k+2, and `dma_req` or `irq_req` follows at edge k+3.
- R5: Modes 5, 6 and 7 set the flag on a rising edge, a falling edge and either edge respectively, and raise neither output.
- R6: Modes 9, 10 and 11 set the flag on a rising edge, a falling edge and either edge respectively, and assert `irq_req`.
- R7: Mode 8 sets the flag while the input is low, and mode 12 sets it while the input is high. Both assert `irq_req`. A flag cleared while its level is still present reads as set again.
- R8: Bit n of the status word is the flag of pin n, so events on pins 0 and 16 read as 0x00010001.
- R9: Writing the status address clears every flag whose data bit is one. Bits written as zero keep their value.
- R10: A one-cycle `dma_done` pulse clears the flags of pins in modes 1 to 3, and leaves the flags of all other pins unchanged.
- R11: Writing address 33 applies data bits [3:0] as the mode of each pin n in 0..15 for which data bit 16+n is one. Address 34 does the same for pins 16..31, using data bit 16+(n-16) as the mask.
- R12: When a set condition and a clear (a status write or `dma_done`) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Asynchronous port pin inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dma_done | input | 1 | DMA transfer-complete pulse |
| irq_req | output | 1 | OR of flags of pins in modes 8 to 12 |
| dma_req | output | 1 | OR of flags of pins in modes 1 to 3 |

## Verification
The bench walks every trigger mode with the edge or level that should fire it and with one that should not. This catches a design that swaps rising and falling detection, or that lets the unused codes 4 and 13 to 15 raise flags. It clears a level-triggered flag while the level is still present; a design that treated levels as one-shot would then read zero. It lines a status clear up with the exact cycle in which an edge event lands, where a clear-first design would lose the event. It also pulses the DMA-complete input while a DMA pin and an interrupt pin are both flagged, where a design that cleared all flags would drop the interrupt. The two bulk registers are checked against a masked single write and its unmasked neighbours, and the output timing is checked to the edge.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_OFF      = 4'd0;
  localparam logic [MODE_W-1:0] MD_DMA_RISE = 4'd1;
  localparam logic [MODE_W-1:0] MD_DMA_FALL = 4'd2;
  localparam logic [MODE_W-1:0] MD_DMA_BOTH = 4'd3;
  localparam logic [MODE_W-1:0] MD_FLG_RISE = 4'd5;
  localparam logic [MODE_W-1:0] MD_FLG_FALL = 4'd6;
  localparam logic [MODE_W-1:0] MD_FLG_BOTH = 4'd7;
  localparam logic [MODE_W-1:0] MD_IRQ_LOW  = 4'd8;
  localparam logic [MODE_W-1:0] MD_IRQ_RISE = 4'd9;
  localparam logic [MODE_W-1:0] MD_IRQ_FALL = 4'd10;
  localparam logic [MODE_W-1:0] MD_IRQ_BOTH = 4'd11;
  localparam logic [MODE_W-1:0] MD_IRQ_HIGH = 4'd12;

  function automatic logic mode_is_dma(logic [MODE_W-1:0] m);
    return (m >= MD_DMA_RISE) && (m <= MD_DMA_BOTH);
  endfunction

  function automatic logic mode_is_irq(logic [MODE_W-1:0] m);
    return (m >= MD_IRQ_LOW) && (m <= MD_IRQ_HIGH);
  endfunction

  // Set condition of one pin given its mode, current and previous sample.
  function automatic logic mode_event(logic [MODE_W-1:0] m, logic cur, logic old);
    logic rise;
    logic fall;
    rise = cur & ~old;
    fall = ~cur & old;
    case (m)
      MD_DMA_RISE, MD_FLG_RISE, MD_IRQ_RISE: return rise;
      MD_DMA_FALL, MD_FLG_FALL, MD_IRQ_FALL: return fall;
      MD_DMA_BOTH, MD_FLG_BOTH, MD_IRQ_BOTH: return rise | fall;
      MD_IRQ_LOW:                            return ~cur;
      MD_IRQ_HIGH:                           return cur;
      default:                               return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pid_sync.sv
module pid_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] lvl_prev
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic meta_q;
    logic sync_q;
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign lvl[i]      = sync_q;
    assign lvl_prev[i] = prev_q;
  end
endmodule

// File: rtl/pid_cfg.sv
module pid_cfg
  import pid_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter int GRP       = 16,
  parameter int DW        = 32,
  parameter int AW        = 6,
  parameter int BULK_BASE = 33
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic [AW-1:0]                reg_addr,
  input  logic [DW-1:0]                reg_wdata,
  output logic [NPINS-1:0][MODE_W-1:0] mode_q
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int G = i / GRP;
    localparam int B = i % GRP;
    logic single_hit;
    logic bulk_hit;
    assign single_hit = reg_wr && (reg_addr == AW'(i));
    assign bulk_hit   = reg_wr && (reg_addr == AW'(BULK_BASE + G)) && reg_wdata[GRP + B];
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[i] <= MD_OFF;
      end else if (single_hit || bulk_hit) begin
        mode_q[i] <= reg_wdata[MODE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pid_flags.sv
module pid_flags
  import pid_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPINS-1:0]             lvl,
  input  logic [NPINS-1:0]             lvl_prev,
  input  logic [NPINS-1:0][MODE_W-1:0] mode_q,
  input  logic [NPINS-1:0]             clr_mask,
  input  logic                         dma_done,
  output logic [NPINS-1:0]             flag_q
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic set_now;
    logic clr_now;
    always_comb begin
      set_now = mode_event(mode_q[i], lvl[i], lvl_prev[i]);
      clr_now = clr_mask[i] | (dma_done & mode_is_dma(mode_q[i]));
    end
    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
      end else if (set_now) begin
        flag_q[i] <= 1'b1;
      end else if (clr_now) begin
        flag_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pid_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int GRP   = 16,
  parameter int DW    = 32,
  localparam int NGRP      = NPINS / GRP,
  localparam int STAT_ADDR = NPINS,
  localparam int BULK_BASE = NPINS + 1,
  localparam int AW        = $clog2(NPINS + 1 + NGRP),
  localparam int PW        = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             dma_done,
  output logic             irq_req,
  output logic             dma_req
);
  logic [NPINS-1:0]             sync_lvl;
  logic [NPINS-1:0]             sync_prev;
  logic [NPINS-1:0][MODE_W-1:0] mode_q;
  logic [NPINS-1:0]             flag_q;
  logic [NPINS-1:0]             clr_mask;
  logic [NPINS-1:0]             irq_en;
  logic [NPINS-1:0]             dma_en;

  pid_sync #(.NPINS(NPINS)) sync_i (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .lvl(sync_lvl), .lvl_prev(sync_prev)
  );

  pid_cfg #(.NPINS(NPINS), .GRP(GRP), .DW(DW), .AW(AW), .BULK_BASE(BULK_BASE)) cfg_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mode_q(mode_q)
  );

  assign clr_mask = (reg_wr && (reg_addr == AW'(STAT_ADDR))) ? reg_wdata[NPINS-1:0] : '0;

  pid_flags #(.NPINS(NPINS)) flags_i (
    .clk(clk), .rst(rst), .lvl(sync_lvl), .lvl_prev(sync_prev),
    .mode_q(mode_q), .clr_mask(clr_mask), .dma_done(dma_done), .flag_q(flag_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_en
    assign irq_en[i] = mode_is_irq(mode_q[i]);
    assign dma_en[i] = mode_is_dma(mode_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      dma_req   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq_req <= |(flag_q & irq_en);
      dma_req <= |(flag_q & dma_en);
      if (reg_addr < AW'(NPINS)) begin
        reg_rdata <= DW'(mode_q[reg_addr[PW-1:0]]);
      end else if (reg_addr == AW'(STAT_ADDR)) begin
        reg_rdata <= DW'(flag_q);
      end else begin
        reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pid_chk.sv
module pid_chk
  import pid_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         reg_wr,
  input logic [AW-1:0]                reg_addr,
  input logic                         dma_done,
  input logic                         irq_req,
  input logic                         dma_req,
  input logic [NPINS-1:0]             flags,
  input logic [NPINS-1:0][MODE_W-1:0] modes,
  input logic [NPINS-1:0]             lvl
);
  logic [NPINS-1:0] off_mask;
  logic [NPINS-1:0] hi_mask;
  logic [NPINS-1:0] dmam;
  logic             stat_wr;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      off_mask[i] = (modes[i] == 4'd0) || (modes[i] == 4'd4) || (modes[i] >= 4'd13);
      hi_mask[i]  = (modes[i] == 4'd12);
      dmam[i]     = (modes[i] >= 4'd1) && (modes[i] <= 4'd3);
    end
  end
  assign stat_wr = reg_wr && (reg_addr == AW'(NPINS));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags == '0) && !irq_req && !dma_req);

  // R3
  off_mode_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (flags & ~$past(flags) & $past(off_mask)) == '0);

  // R9
  fall_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((~flags & $past(flags)) != '0) |-> $past(stat_wr || dma_done));

  // R10
  dma_done_scope_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dma_done && !stat_wr) |-> ((~flags & $past(flags) & ~$past(dmam)) == '0));

  // R7
  level_high_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hi_mask & lvl) & ~flags) == '0);

  // R4
  no_flag_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flags) == '0) |-> (!irq_req && !dma_req));
endmodule

bind pin_irq_detect pid_chk #(.NPINS(NPINS), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .dma_done(dma_done), .irq_req(irq_req), .dma_req(dma_req),
  .flags(flag_q), .modes(mode_q), .lvl(sync_lvl)
);

// File: tb/pin_irq_detect_tb_top.sv
module pin_irq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_done = 1'b0;
  logic        irq_req;
  logic        dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [5:0] STAT = 6'd32;
  localparam logic [5:0] BLO  = 6'd33;
  localparam logic [5:0] BHI  = 6'd34;

  // {mode[3:0], before, after, flag, irq, dma}
  localparam int NV = 18;
  localparam logic [8:0] VEC [NV] = '{
    {4'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd2,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'd6,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd7,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd8,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd8,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd9,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd12, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd13, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd9,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  pin_irq_detect dut_i (
    .clk(clk), .rst(rst), .pin_in(pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_done(dma_done),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic string req_of(input logic [3:0] m);
    if (m >= 4'd1 && m <= 4'd3) return "R4";
    if (m >= 4'd5 && m <= 4'd7) return "R5";
    if (m == 4'd8 || m == 4'd12) return "R7";
    if (m >= 4'd9 && m <= 4'd11) return "R6";
    return "R3";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pins = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    do_reset();
    // R1 reset state
    chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
    chk("R1 dma_req", {31'd0, dma_req}, 32'd0);
    rd_reg(STAT, rd); chk("R1 status", rd, 32'd0);
    rd_reg(6'd7, rd); chk("R1 R2 mode", rd, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] m;
      string rq;
      m  = VEC[v][8:5];
      rq = req_of(m);
      @(negedge clk);
      pins[v] = VEC[v][4];
      repeat (5) @(negedge clk);
      reg_wr = 1'b1; reg_addr = 6'(v); reg_wdata = {28'd0, m}; pins[v] = VEC[v][3];
      @(negedge clk);
      reg_wr = 1'b0;
      repeat (6) @(negedge clk);
      chk({rq, " irq"}, {31'd0, irq_req}, {31'd0, VEC[v][1]});
      chk({rq, " dma"}, {31'd0, dma_req}, {31'd0, VEC[v][0]});
      rd_reg(STAT, rd);
      chk({rq, " R8 flag"}, rd, VEC[v][2] ? (32'd1 << v) : 32'd0);
      wr_reg(6'(v), 32'd0);
      wr_reg(STAT, 32'hFFFF_FFFF);
    end

    do_reset();
    // R11 bulk writes
    wr_reg(BLO, {16'h0005, 16'h0009});
    wr_reg(BHI, {16'h0001, 16'h0009});
    rd_reg(6'd0, rd);  chk("R11 pin0", rd, 32'd9);
    rd_reg(6'd1, rd);  chk("R11 pin1", rd, 32'd0);
    rd_reg(6'd2, rd);  chk("R11 pin2", rd, 32'd9);
    rd_reg(6'd16, rd); chk("R11 pin16", rd, 32'd9);
    rd_reg(6'd17, rd); chk("R11 pin17", rd, 32'd0);
    rd_reg(6'd18, rd); chk("R11 pin18", rd, 32'd0);

    // R8 bit mapping
    @(negedge clk);
    pins[0] = 1'b1; pins[16] = 1'b1;
    repeat (6) @(negedge clk);
    rd_reg(STAT, rd); chk("R8 status", rd, 32'h0001_0001);
    chk("R6 irq", {31'd0, irq_req}, 32'd1);

    // R9 write one to clear
    wr_reg(STAT, 32'h0000_0001);
    rd_reg(STAT, rd); chk("R9 clear bit0", rd, 32'h0001_0000);
    wr_reg(STAT, 32'h0000_0000);
    rd_reg(STAT, rd); chk("R9 zero write", rd, 32'h0001_0000);
    wr_reg(STAT, 32'h0001_0000);
    rd_reg(STAT, rd); chk("R9 clear bit16", rd, 32'd0);
    chk("R9 irq low", {31'd0, irq_req}, 32'd0);

    // R7 level re-sets after clear
    wr_reg(6'd3, 32'd12);
    @(negedge clk); pins[3] = 1'b1;
    repeat (6) @(negedge clk);
    wr_reg(STAT, 32'h0000_0008);
    rd_reg(STAT, rd); chk("R7 reassert", rd, 32'h0000_0008);
    chk("R7 irq", {31'd0, irq_req}, 32'd1);
    @(negedge clk); pins[3] = 1'b0;
    repeat (6) @(negedge clk);
    wr_reg(STAT, 32'h0000_0008);
    rd_reg(STAT, rd); chk("R7 level gone", rd, 32'd0);
    wr_reg(6'd3, 32'd0);

    // R10 DMA complete clears DMA-mode flags only
    wr_reg(6'd5, 32'd1);
    wr_reg(6'd6, 32'd9);
    @(negedge clk); pins[5] = 1'b1; pins[6] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 dma before", {31'd0, dma_req}, 32'd1);
    rd_reg(STAT, rd); chk("R10 status before", rd, 32'h0000_0060);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    repeat (2) @(negedge clk);
    rd_reg(STAT, rd); chk("R10 status after", rd, 32'h0000_0040);
    chk("R10 dma after", {31'd0, dma_req}, 32'd0);
    chk("R10 irq kept", {31'd0, irq_req}, 32'd1);

    // R4 latency: change before edge k, dma_req at edge k+3
    wr_reg(6'd8, 32'd1);
    @(negedge clk); pins[8] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 dma at k+2", {31'd0, dma_req}, 32'd0);
    @(negedge clk);
    chk("R4 dma at k+3", {31'd0, dma_req}, 32'd1);

    // R12 set wins over a clear in the same cycle
    wr_reg(STAT, 32'hFFFF_FFFF);
    wr_reg(6'd7, 32'd5);
    @(negedge clk); pins[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = STAT; reg_wdata = 32'h0000_0080;
    @(negedge clk); reg_wr = 1'b0;
    rd_reg(STAT, rd); chk("R12 set priority", rd & 32'h0000_0080, 32'h0000_0080);
    wr_reg(STAT, 32'h0000_0080);
    rd_reg(STAT, rd); chk("R9 later clear", rd & 32'h0000_0080, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule